// File: doc/BRIEF.md
# Operand-Snooping Reservation Station

This block holds a small set of waiting operations in front of one functional unit of an out-of-order core. When an operation is issued, each of its two source operands arrives either as a finished value or as the tag of the operation that will produce it. Operands that are still waiting listen to the common result bus. When a broadcast carries a matching tag they take its value. An operation whose two operands are both present becomes eligible to start. Among the eligible operations, the one that has waited longest is sent to a fixed-latency add/subtract pipe. The pipe's result leaves the block together with the tag of the slot that held the operation.

The surrounding core feeds the result output back onto the shared bus and decides which producer owns the bus in each cycle. The block itself never drives the bus. Issue is refused while the station is full. It is also refused while a branch is outstanding: the core raises a set pulse when a branch is issued elsewhere and a resolve pulse when that branch settles. A slot stays occupied until its result has been broadcast, so a tag never names two live operations.

Top module: `rs_station`

## Requirements
- R1: After reset `iss_ready` is 1 and `res_valid` is 0.
- R2: An operation whose two source tags are both 0 is accepted in cycle i and shows its result on `res_valid` in cycle i+1+LATENCY, and not before.
- R3: A source tag of 0 means the value field is valid. A nonzero source tag makes the operation wait, with no result, until the bus carries that tag. The operation then uses the broadcast value.
- R4: If the bus carries an operand's tag in the same cycle that the operand is issued, the bus value is taken directly and no later broadcast is needed.
- R5: At most one operation starts per cycle. When several become eligible in the same cycle, the one issued earliest starts first, whatever slot it occupies.
- R6: Every accepted operation produces exactly one result, tagged with the `iss_tag` shown when it was accepted. Two consecutive results never carry the same tag.
- R7: `iss_ready` is 0 while all DEPTH slots are occupied. A slot becomes free in the cycle after its result is shown.
- R8: A `br_set` pulse drops `iss_ready` from the next cycle on, and `iss_valid` is ignored meanwhile. `iss_ready` returns in the cycle after a `br_resolve` pulse. If both pulses arrive together, the set wins.
- R9: `iss_op` 0 gives a+b and `iss_op` 1 gives a-b, both modulo 2^DATA_W, where a and b are the first and second source.
- R10: `iss_tag` equals TAG_BASE plus the index of the lowest free slot, so every result tag lies in TAG_BASE..TAG_BASE+DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_ready | output | 1 | Station can accept an operation this cycle |
| iss_op | input | 1 | 0 add, 1 subtract |
| iss_a_tag | input | TAG_W | Producer tag of first source, 0 when the value is valid |
| iss_a_val | input | DATA_W | Value of first source |
| iss_b_tag | input | TAG_W | Producer tag of second source, 0 when the value is valid |
| iss_b_val | input | DATA_W | Value of second source |
| iss_tag | output | TAG_W | Tag given to the operation accepted this cycle |
| br_set | input | 1 | A branch has been issued and is unresolved |
| br_resolve | input | 1 | The outstanding branch has settled |
| cdb_valid | input | 1 | Common bus carries a result |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Value of the broadcast result |
| res_valid | output | 1 | Unit result available for broadcast |
| res_tag | output | TAG_W | Tag of the finished operation |
| res_val | output | DATA_W | Result value |

## Verification
The bench builds the station with its defaults: DEPTH 4, TAG_W 3, DATA_W 16, LATENCY 2 and TAG_BASE 1. Station tags are therefore 1 to 4, and tags 5 to 7 are free to act as external producers driven straight onto the bus. Because there are only four slots, a few waiting operations are enough to reach the full stall. The same small depth makes it easy to place a younger operation in a lower slot than an older one, which exposes the age ordering. The 16-bit width makes wrap-around of add and subtract directly visible.

// File: rtl/rs_pkg.sv
package rs_pkg;

   typedef enum logic {
      RS_OP_ADD = 1'b0,
      RS_OP_SUB = 1'b1
   } rs_op_e;

   localparam int RS_NUM_SRC = 2;

endpackage

// File: rtl/rs_operand.sv
// One source operand slot: holds a value, or waits on a producer tag and
// snoops the common bus for it.
module rs_operand #(
   parameter int TAG_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  src_tag,
   input  logic [DATA_W-1:0] src_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              have_o,
   output logic [DATA_W-1:0] val_o
);
   logic              have_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              hit_wait;
   logic              hit_load;

   assign hit_wait = cdb_valid && (cdb_tag == tag_q);
   assign hit_load = cdb_valid && (cdb_tag == src_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= '0;
      end else if (load) begin
         tag_q <= src_tag;
         if (src_tag == '0) begin
            have_q <= 1'b1;
            val_q  <= src_val;
         end else if (hit_load) begin
            have_q <= 1'b1;
            val_q  <= cdb_val;
         end else begin
            have_q <= 1'b0;
         end
      end else if (!have_q && hit_wait) begin
         have_q <= 1'b1;
         val_q  <= cdb_val;
      end
   end

   assign have_o = have_q;
   assign val_o  = val_q;
endmodule

// File: rtl/rs_entry.sv
// One station slot: occupancy, started flag, opcode and two operands.
module rs_entry
   import rs_pkg::*;
#(
   parameter int TAG_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  rs_op_e            op_in,
   input  logic [TAG_W-1:0]  src_tag [RS_NUM_SRC],
   input  logic [DATA_W-1:0] src_val [RS_NUM_SRC],
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   input  logic              start,
   input  logic              retire,
   output logic              valid_o,
   output logic              ready_o,
   output rs_op_e            op_o,
   output logic [DATA_W-1:0] opnd_o [RS_NUM_SRC]
);
   logic                  valid_q;
   logic                  sent_q;
   rs_op_e                op_q;
   logic [RS_NUM_SRC-1:0] have;

   for (genvar k = 0; k < RS_NUM_SRC; k++) begin : g_src
      rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (alloc),
         .src_tag  (src_tag[k]),
         .src_val  (src_val[k]),
         .cdb_valid(cdb_valid),
         .cdb_tag  (cdb_tag),
         .cdb_val  (cdb_val),
         .have_o   (have[k]),
         .val_o    (opnd_o[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         sent_q  <= 1'b0;
         op_q    <= RS_OP_ADD;
      end else if (alloc) begin
         valid_q <= 1'b1;
         sent_q  <= 1'b0;
         op_q    <= op_in;
      end else begin
         if (start)  sent_q  <= 1'b1;
         if (retire) valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign ready_o = valid_q && !sent_q && (&have);
   assign op_o    = op_q;
endmodule

// File: rtl/rs_age_select.sv
// Age matrix: older_q[j][i] set means slot j was issued before slot i.
// Grants the oldest ready slot, one per cycle.
module rs_age_select #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc_vec,
   input  logic [DEPTH-1:0] ready,
   output logic [DEPTH-1:0] grant
);
   logic [DEPTH-1:0] older_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_vec[i]) begin
               for (int j = 0; j < DEPTH; j++) begin
                  if (j != i) begin
                     older_q[i][j] <= 1'b0;
                     older_q[j][i] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && ready[j] && older_q[j][i]) blocked = 1'b1;
         end
         grant[i] = ready[i] && !blocked;
      end
   end
endmodule

// File: rtl/rs_fu_pipe.sv
// Fixed-latency stand-in for the functional unit: carries the finished value
// and the slot index through LATENCY register stages.
module rs_fu_pipe #(
   parameter int DATA_W  = 16,
   parameter int IDX_W   = 2,
   parameter int LATENCY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [DATA_W-1:0] in_val,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_val
);
   if (LATENCY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_val   <= '0;
         end else begin
            out_valid <= in_valid;
            out_idx   <= in_idx;
            out_val   <= in_val;
         end
      end
   end else begin : g_multi
      logic              v_q   [LATENCY];
      logic [IDX_W-1:0]  idx_q [LATENCY];
      logic [DATA_W-1:0] val_q [LATENCY];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < LATENCY; s++) begin
               v_q[s]   <= 1'b0;
               idx_q[s] <= '0;
               val_q[s] <= '0;
            end
         end else begin
            v_q[0]   <= in_valid;
            idx_q[0] <= in_idx;
            val_q[0] <= in_val;
            for (int s = 1; s < LATENCY; s++) begin
               v_q[s]   <= v_q[s-1];
               idx_q[s] <= idx_q[s-1];
               val_q[s] <= val_q[s-1];
            end
         end
      end

      assign out_valid = v_q[LATENCY-1];
      assign out_idx   = idx_q[LATENCY-1];
      assign out_val   = val_q[LATENCY-1];
   end
endmodule

// File: rtl/rs_station.sv
module rs_station
   import rs_pkg::*;
#(
   parameter int DEPTH    = 4,
   parameter int TAG_W    = 3,
   parameter int DATA_W   = 16,
   parameter int LATENCY  = 2,
   parameter int TAG_BASE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic              iss_op,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic              br_set,
   input  logic              br_resolve,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              res_valid,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_val
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rs_station: DEPTH must be at least 2");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("rs_station: LATENCY must be at least 1");
   end
   if (TAG_BASE < 1 || TAG_BASE + DEPTH > (1 << TAG_W)) begin : g_bad_tag
      $error("rs_station: slot tags must be nonzero and fit in TAG_W");
   end

   logic [DEPTH-1:0]  ent_valid;
   logic [DEPTH-1:0]  ent_ready;
   logic [DEPTH-1:0]  grant;
   logic [DEPTH-1:0]  alloc_vec;
   logic [DEPTH-1:0]  release_vec;
   rs_op_e            ent_op   [DEPTH];
   logic [DATA_W-1:0] ent_opnd [DEPTH][RS_NUM_SRC];
   logic [TAG_W-1:0]  src_tag  [RS_NUM_SRC];
   logic [DATA_W-1:0] src_val  [RS_NUM_SRC];

   logic              br_pend_q;
   logic [IDX_W-1:0]  free_idx;
   logic              full;
   logic              accept;

   logic              disp_valid;
   logic [IDX_W-1:0]  disp_idx;
   rs_op_e            disp_op;
   logic [DATA_W-1:0] disp_a;
   logic [DATA_W-1:0] disp_b;
   logic [DATA_W-1:0] disp_res;
   logic [IDX_W-1:0]  res_idx;

   // branch issue block
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          br_pend_q <= 1'b0;
      else if (br_set)     br_pend_q <= 1'b1;
      else if (br_resolve) br_pend_q <= 1'b0;
   end

   // lowest free slot
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!ent_valid[i]) free_idx = IDX_W'(i);
      end
   end

   assign full      = &ent_valid;
   assign iss_ready = !full && !br_pend_q;
   assign accept    = iss_valid && iss_ready;
   assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

   always_comb begin
      alloc_vec = '0;
      if (accept) alloc_vec[free_idx] = 1'b1;
   end

   assign src_tag[0] = iss_a_tag;
   assign src_tag[1] = iss_b_tag;
   assign src_val[0] = iss_a_val;
   assign src_val[1] = iss_b_val;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (alloc_vec[i]),
         .op_in    (rs_op_e'(iss_op)),
         .src_tag  (src_tag),
         .src_val  (src_val),
         .cdb_valid(cdb_valid),
         .cdb_tag  (cdb_tag),
         .cdb_val  (cdb_val),
         .start    (grant[i]),
         .retire   (release_vec[i]),
         .valid_o  (ent_valid[i]),
         .ready_o  (ent_ready[i]),
         .op_o     (ent_op[i]),
         .opnd_o   (ent_opnd[i])
      );
   end

   rs_age_select #(.DEPTH(DEPTH)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_vec(alloc_vec),
      .ready    (ent_ready),
      .grant    (grant)
   );

   // dispatch mux
   always_comb begin
      disp_idx = '0;
      disp_op  = RS_OP_ADD;
      disp_a   = '0;
      disp_b   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) begin
            disp_idx = IDX_W'(i);
            disp_op  = ent_op[i];
            disp_a   = ent_opnd[i][0];
            disp_b   = ent_opnd[i][1];
         end
      end
   end

   assign disp_valid = |grant;
   assign disp_res   = (disp_op == RS_OP_SUB) ? (disp_a - disp_b) : (disp_a + disp_b);

   rs_fu_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LATENCY(LATENCY)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (disp_valid),
      .in_idx   (disp_idx),
      .in_val   (disp_res),
      .out_valid(res_valid),
      .out_idx  (res_idx),
      .out_val  (res_val)
   );

   assign res_tag = TAG_W'(TAG_BASE) + TAG_W'(res_idx);

   always_comb begin
      release_vec = '0;
      if (res_valid) release_vec[res_idx] = 1'b1;
   end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
   parameter int DEPTH    = 4,
   parameter int TAG_W    = 3,
   parameter int TAG_BASE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_ready,
   input logic             br_set,
   input logic [DEPTH-1:0] ent_valid,
   input logic [DEPTH-1:0] ent_ready,
   input logic [DEPTH-1:0] grant,
   input logic             res_valid,
   input logic [TAG_W-1:0] res_tag
);
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (&ent_valid) |-> !iss_ready); // R7

   AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      br_set |=> !iss_ready); // R8

   AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R5

   AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~ent_ready) == '0); // R3

   AST_RES_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (int'(res_tag) >= TAG_BASE && int'(res_tag) < TAG_BASE + DEPTH)); // R10

   AST_RES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(res_valid)) |-> (res_tag != $past(res_tag))); // R6
endmodule

bind rs_station rs_station_chk #(
   .DEPTH   (DEPTH),
   .TAG_W   (TAG_W),
   .TAG_BASE(TAG_BASE)
) u_rs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_ready(iss_ready),
   .br_set   (br_set),
   .ent_valid(ent_valid),
   .ent_ready(ent_ready),
   .grant    (grant),
   .res_valid(res_valid),
   .res_tag  (res_tag)
);

// File: tb/rs_station_bench.sv
`timescale 1ns/100ps
module rs_station_bench;
   localparam int TW = 3;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic          iss_ready;
   logic          iss_op = 1'b0;
   logic [TW-1:0] iss_a_tag = '0;
   logic [DW-1:0] iss_a_val = '0;
   logic [TW-1:0] iss_b_tag = '0;
   logic [DW-1:0] iss_b_val = '0;
   logic [TW-1:0] iss_tag;
   logic          br_set = 1'b0;
   logic          br_resolve = 1'b0;
   logic          cdb_valid;
   logic [TW-1:0] cdb_tag;
   logic [DW-1:0] cdb_val;
   logic          res_valid;
   logic [TW-1:0] res_tag;
   logic [DW-1:0] res_val;

   logic          ext_v = 1'b0;
   logic [TW-1:0] ext_tag = '0;
   logic [DW-1:0] ext_val = '0;

   // the core's bus: own result has the bus when present, else external producer
   assign cdb_valid = res_valid | ext_v;
   assign cdb_tag   = res_valid ? res_tag : ext_tag;
   assign cdb_val   = res_valid ? res_val : ext_val;

   always #2.5 clk = ~clk;

   rs_station u_rs_station (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
      .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val), .iss_tag(iss_tag),
      .br_set(br_set), .br_resolve(br_resolve),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
      .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val)
   );

   typedef struct packed {
      logic [TW-1:0] tag;
      logic [DW-1:0] val;
   } exp_t;

   exp_t exp_q [$];
   int   n_checks = 0;
   int   n_fail   = 0;
   int   n_res    = 0;

   task automatic chk(input logic ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // monitor: every result must match an outstanding expectation (R6, R9)
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         int hit;
         hit = -1;
         n_res++;
         for (int k = 0; k < exp_q.size(); k++) begin
            if (hit < 0 && exp_q[k].tag == res_tag) hit = k;
         end
         if (hit < 0) begin
            chk(1'b0, "R6 unexpected result tag", int'(res_tag), -1);
         end else begin
            chk(res_val == exp_q[hit].val, "R9 result value", int'(res_val), int'(exp_q[hit].val));
            exp_q.delete(hit);
         end
      end
   end

   task automatic do_issue(input logic op, input logic [TW-1:0] at, input logic [DW-1:0] av,
                           input logic [TW-1:0] bt, input logic [DW-1:0] bv,
                           input logic [DW-1:0] expv, output logic [TW-1:0] tg);
      @(negedge clk);
      iss_valid = 1'b1; iss_op = op;
      iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
      while (!iss_ready) @(negedge clk);
      tg = iss_tag;
      exp_q.push_back('{tag: tg, val: expv});
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
      @(negedge clk);
      ext_v = 1'b1; ext_tag = t; ext_val = v;
      @(negedge clk);
      ext_v = 1'b0;
   endtask

   task automatic run_tests;
      logic [TW-1:0] t1, t2, t3;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(iss_ready == 1'b1, "R1 ready after reset", int'(iss_ready), 1);
      chk(res_valid == 1'b0, "R1 no result after reset", int'(res_valid), 0);

      // R2 latency with ready operands
      do_issue(1'b0, 3'd0, 16'd10, 3'd0, 16'd20, 16'd30, t1);
      chk(res_valid == 1'b0, "R2 no result at i+1", int'(res_valid), 0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R2 no result at i+2", int'(res_valid), 0);
      @(negedge clk);
      chk(res_valid == 1'b1, "R2 result at i+1+LATENCY", int'(res_valid), 1);
      chk(res_tag == t1, "R6 result carries issue tag", int'(res_tag), int'(t1));
      repeat (3) @(negedge clk);

      // R9 subtract and wrap-around
      do_issue(1'b1, 3'd0, 16'd3, 3'd0, 16'd5, 16'hFFFE, t1);
      repeat (4) @(negedge clk);
      do_issue(1'b0, 3'd0, 16'hFFFF, 3'd0, 16'd2, 16'd1, t1);
      repeat (4) @(negedge clk);

      // R3 wait on external tag 5
      do_issue(1'b1, 3'd5, 16'd0, 3'd0, 16'd3, 16'd6, t1);
      base = n_res;
      repeat (6) @(negedge clk);
      chk(n_res == base, "R3 waiting op gives no result", n_res - base, 0);
      bcast(3'd5, 16'd9);
      repeat (5) @(negedge clk);
      chk(n_res == base + 1, "R3 result after broadcast", n_res - base, 1);

      // R4 same-cycle capture at issue
      @(negedge clk);
      iss_valid = 1'b1; iss_op = 1'b0;
      iss_a_tag = 3'd6; iss_a_val = 16'd0; iss_b_tag = 3'd0; iss_b_val = 16'd2;
      ext_v = 1'b1; ext_tag = 3'd6; ext_val = 16'd40;
      chk(iss_ready == 1'b1, "R4 ready for same-cycle issue", int'(iss_ready), 1);
      exp_q.push_back('{tag: iss_tag, val: 16'd42});
      base = n_res;
      @(negedge clk);
      iss_valid = 1'b0; ext_v = 1'b0;
      repeat (5) @(negedge clk);
      chk(n_res == base + 1, "R4 captured bus value at issue", n_res - base, 1);

      // R3 dependency on own result through the bus
      do_issue(1'b0, 3'd0, 16'd10, 3'd0, 16'd20, 16'd30, t1);
      do_issue(1'b1, t1, 16'd0, 3'd0, 16'd5, 16'd25, t2);
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R3 dependent chain completed", exp_q.size(), 0);

      // R5 oldest first, younger op sits in lower slot
      do_issue(1'b0, 3'd0, 16'd1, 3'd0, 16'd1, 16'd2, t1);
      do_issue(1'b0, 3'd7, 16'd0, 3'd0, 16'd1, 16'd51, t2);
      repeat (3) @(negedge clk);
      do_issue(1'b1, 3'd7, 16'd0, 3'd0, 16'd2, 16'd48, t3);
      chk(t2 == 3'd2, "R10 older op tag", int'(t2), 2);
      chk(t3 == 3'd1, "R10 lowest free slot reused", int'(t3), 1);
      bcast(3'd7, 16'd50);
      for (int w = 0; w < 10 && !res_valid; w++) @(negedge clk);
      chk(res_valid && res_tag == t2, "R5 oldest ready starts first", int'(res_tag), int'(t2));
      @(negedge clk);
      chk(res_valid && res_tag == t3, "R5 younger follows next cycle", int'(res_tag), int'(t3));
      repeat (4) @(negedge clk);

      // R7 / R10 fill all slots
      for (int k = 0; k < 4; k++) begin
         do_issue(1'b0, 3'd5, 16'd0, 3'd0, 16'(k), 16'(100 + k), t1);
         chk(t1 == 3'(k + 1), "R10 tag order on fill", int'(t1), k + 1);
      end
      chk(iss_ready == 1'b0, "R7 not ready when full", int'(iss_ready), 0);
      bcast(3'd5, 16'd100);
      repeat (8) @(negedge clk);
      chk(iss_ready == 1'b1, "R7 ready after slots drain", int'(iss_ready), 1);
      chk(exp_q.size() == 0, "R7 all full-station results seen", exp_q.size(), 0);

      // R8 branch block
      @(negedge clk);
      br_set = 1'b1;
      @(negedge clk);
      br_set = 1'b0;
      chk(iss_ready == 1'b0, "R8 not ready after branch set", int'(iss_ready), 0);
      base = n_res;
      iss_valid = 1'b1; iss_op = 1'b0;
      iss_a_tag = 3'd0; iss_a_val = 16'd7; iss_b_tag = 3'd0; iss_b_val = 16'd7;
      repeat (4) @(negedge clk);
      iss_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(n_res == base, "R8 issue ignored while branch pending", n_res - base, 0);
      chk(iss_ready == 1'b0, "R8 still blocked before resolve", int'(iss_ready), 0);
      br_resolve = 1'b1;
      @(negedge clk);
      br_resolve = 1'b0;
      chk(iss_ready == 1'b1, "R8 ready after resolve", int'(iss_ready), 1);
      do_issue(1'b0, 3'd0, 16'd7, 3'd0, 16'd8, 16'd15, t1);
      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R6 every issued op produced one result", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule